// File: doc/BRIEF.md
# Pixel to Bit-Plane Transposer

This block turns 24-bit colour pixels, each aimed at one output lane, into the bit-plane memory that a parallel serial-LED waveform generator reads. Each word of the plane memory holds one bit time for every lane at once, so bit i of a word belongs to lane i. A pixel command names a lane, an LED position and three colour bytes. The block then rewrites the 24 words that belong to that LED, changing only the selected lane's bit in each word so that the other lanes stay intact.

The plane memory is a single-port synchronous RAM inside the block. The waveform generator reads it through a dedicated read port. While the generator holds its active flag, it owns the RAM. New commands are refused, and any update already in progress pauses, so the generator never sees a partly edited frame. A blank command clears the whole memory. An out-of-range lane or LED index is dropped and reported with a one-cycle error pulse.

Top module: `pixel_plane_xpose`

## Requirements
- R1: After reset, with `gen_active` low, `ready` is high and `err` is low.
- R2: LED n of a lane occupies words n*24 to n*24+23. The green byte fills word offsets 0 to 7, the red byte fills 8 to 15, and the blue byte fills 16 to 23.
- R3: Within each colour byte, bit 7 is written to the lowest word offset of its group and bit 0 to the highest.
- R4: A pixel command sets or clears only bit `pix_lane` of each of its 24 words. Every other bit of those words, and every other word, keeps its value.
- R5: A blank command writes zero to all MAX_LEDS*24 words. `ready` is low for exactly MAX_LEDS*24 cycles after the accepting edge.
- R6: A command is accepted on a clock edge where `ready` is high and `pix_valid` or `blank_req` is high. After an accepted in-range pixel command, `ready` is low for exactly 48 cycles (one read cycle and one write cycle per word), then returns high.
- R7: While `gen_active` is high, `ready` is low, the block writes nothing, and a command presented in that time is ignored.
- R8: A pixel command with `pix_lane` >= LANES or `pix_led` >= MAX_LEDS changes no memory, keeps `ready` high, and raises `err` for the single cycle after the accepting edge.
- R9: With `gen_active` high, `gen_data` shows the word at `gen_addr` sampled on the previous clock edge.
- R10: If `gen_active` rises during a pixel update, the update pauses and then resumes from the word it was on. The final contents are the same as for an uninterrupted update.
- R11: When `blank_req` and `pix_valid` are both high on the accepting edge, the blank is performed and the pixel is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel command request |
| pix_lane | input | $clog2(LANES)+1 | Target lane index |
| pix_led | input | $clog2(MAX_LEDS)+1 | LED position within the lane |
| pix_grn | input | 8 | Green byte |
| pix_red | input | 8 | Red byte |
| pix_blu | input | 8 | Blue byte |
| blank_req | input | 1 | Clear-all command request |
| gen_active | input | 1 | Waveform generator owns the memory |
| gen_addr | input | $clog2(MAX_LEDS*24) | Generator read address |
| ready | output | 1 | Block can accept a command this cycle |
| err | output | 1 | One-cycle flag for a dropped out-of-range pixel |
| gen_data | output | LANES | Plane word read for the generator |

## Verification
The hardest case to reach from the ports is a generator read that arrives in the middle of a read-modify-write. To create it, the bench issues a pixel command whose target words already hold other lanes' data. It then raises `gen_active` a few cycles later, so the interruption can land between the read of a word and its write-back, and it reads a different address during the pause. When the update finishes, every word is read back and compared with a behavioural memory model. A fixed pause alone does not prove correct resumption; this read-back does. Before that, overlapping lanes are loaded into shared words, which shows that the masked write keeps the neighbouring bits.

// File: rtl/xpose_pkg.sv
package xpose_pkg;

    localparam int BITS_PER_PIX = 24;
    localparam int CNT_W        = 5;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_CLEAR = 2'd3
    } xp_state_e;

    typedef struct packed {
        logic [7:0] grn;
        logic [7:0] red;
        logic [7:0] blu;
    } rgb_t;

    // Serial bit for word offset k: green first, each byte MSB first.
    function automatic logic pick_bit(rgb_t px, logic [CNT_W-1:0] k);
        logic [BITS_PER_PIX-1:0] flat;
        flat = {px.grn, px.red, px.blu};
        return flat[CNT_W'(BITS_PER_PIX - 1) - k];
    endfunction

endpackage

// File: rtl/xpose_plane_ram.sv
module xpose_plane_ram #(
    parameter int W     = 8,
    parameter int DEPTH = 96,
    parameter int AW    = 7
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        rdata <= mem[addr];
    end

endmodule

// File: rtl/xpose_lane_merge.sv
module xpose_lane_merge #(
    parameter int LANES = 8,
    parameter int LW    = 3
) (
    input  logic [LANES-1:0] old_word,
    input  logic [LW-1:0]    lane,
    input  logic             bit_val,
    output logic [LANES-1:0] new_word
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign new_word[i] = (lane == LW'(i)) ? bit_val : old_word[i];
    end

endmodule

// File: rtl/xpose_ctrl.sv
module xpose_ctrl
    import xpose_pkg::*;
#(
    parameter int LANES    = 8,
    parameter int MAX_LEDS = 4,
    parameter int LANE_IW  = 4,
    parameter int LED_IW   = 3,
    parameter int LW       = 3,
    parameter int DEPTH    = 96,
    parameter int AW       = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_valid,
    input  logic [LANE_IW-1:0] pix_lane,
    input  logic [LED_IW-1:0]  pix_led,
    input  rgb_t               pix_px,
    input  logic               blank_req,
    input  logic               gen_active,
    output logic               ready,
    output logic               err,
    output logic               ram_we,
    output logic               wr_clear,
    output logic [AW-1:0]      ptr,
    output logic [LW-1:0]      lane_q,
    output rgb_t               px_q,
    output logic [CNT_W-1:0]   bit_k
);

    xp_state_e state;
    logic      bad_idx;

    assign ready    = (state == ST_IDLE) && !gen_active;
    assign bad_idx  = (pix_lane >= LANE_IW'(LANES)) || (pix_led >= LED_IW'(MAX_LEDS));
    assign ram_we   = !gen_active && ((state == ST_WRITE) || (state == ST_CLEAR));
    assign wr_clear = (state == ST_CLEAR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            ptr    <= '0;
            bit_k  <= '0;
            lane_q <= '0;
            px_q   <= '0;
            err    <= 1'b0;
        end else begin
            err <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (ready && blank_req) begin
                        state <= ST_CLEAR;
                        ptr   <= '0;
                    end else if (ready && pix_valid) begin
                        if (bad_idx) begin
                            err <= 1'b1;
                        end else begin
                            state  <= ST_READ;
                            ptr    <= AW'(pix_led) * AW'(BITS_PER_PIX);
                            bit_k  <= '0;
                            lane_q <= pix_lane[LW-1:0];
                            px_q   <= pix_px;
                        end
                    end
                end
                ST_READ: begin
                    if (!gen_active) begin
                        state <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (gen_active) begin
                        state <= ST_READ;
                    end else if (bit_k == CNT_W'(BITS_PER_PIX - 1)) begin
                        state <= ST_IDLE;
                    end else begin
                        bit_k <= bit_k + 1'b1;
                        ptr   <= ptr + 1'b1;
                        state <= ST_READ;
                    end
                end
                ST_CLEAR: begin
                    if (!gen_active) begin
                        if (ptr == AW'(DEPTH - 1)) begin
                            state <= ST_IDLE;
                        end else begin
                            ptr <= ptr + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pixel_plane_xpose.sv
module pixel_plane_xpose
    import xpose_pkg::*;
#(
    parameter  int LANES    = 8,
    parameter  int MAX_LEDS = 4,
    localparam int LANE_IW  = $clog2(LANES) + 1,
    localparam int LED_IW   = $clog2(MAX_LEDS) + 1,
    localparam int DEPTH    = MAX_LEDS * BITS_PER_PIX,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pix_valid,
    input  logic [LANE_IW-1:0] pix_lane,
    input  logic [LED_IW-1:0]  pix_led,
    input  logic [7:0]         pix_grn,
    input  logic [7:0]         pix_red,
    input  logic [7:0]         pix_blu,
    input  logic               blank_req,
    input  logic               gen_active,
    input  logic [AW-1:0]      gen_addr,
    output logic               ready,
    output logic               err,
    output logic [LANES-1:0]   gen_data
);

    localparam int LW = $clog2(LANES);

    rgb_t             pix_px;
    rgb_t             px_q;
    logic             ram_we;
    logic             wr_clear;
    logic [AW-1:0]    ptr;
    logic [AW-1:0]    ram_addr;
    logic [LW-1:0]    lane_q;
    logic [CNT_W-1:0] bit_k;
    logic [LANES-1:0] ram_q;
    logic [LANES-1:0] merged;
    logic [LANES-1:0] ram_wdata;
    logic             cur_bit;

    assign pix_px    = '{grn: pix_grn, red: pix_red, blu: pix_blu};
    assign ram_addr  = gen_active ? gen_addr : ptr;
    assign cur_bit   = pick_bit(px_q, bit_k);
    assign ram_wdata = wr_clear ? '0 : merged;
    assign gen_data  = ram_q;

    xpose_ctrl #(
        .LANES(LANES), .MAX_LEDS(MAX_LEDS), .LANE_IW(LANE_IW), .LED_IW(LED_IW),
        .LW(LW), .DEPTH(DEPTH), .AW(AW)
    ) u_ctrl (
        .clk(clk), .rst(rst),
        .pix_valid(pix_valid), .pix_lane(pix_lane), .pix_led(pix_led),
        .pix_px(pix_px), .blank_req(blank_req), .gen_active(gen_active),
        .ready(ready), .err(err), .ram_we(ram_we), .wr_clear(wr_clear),
        .ptr(ptr), .lane_q(lane_q), .px_q(px_q), .bit_k(bit_k)
    );

    xpose_lane_merge #(.LANES(LANES), .LW(LW)) u_merge (
        .old_word(ram_q), .lane(lane_q), .bit_val(cur_bit), .new_word(merged)
    );

    xpose_plane_ram #(.W(LANES), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(clk), .we(ram_we), .addr(ram_addr), .wdata(ram_wdata), .rdata(ram_q)
    );

endmodule

// File: rtl/xpose_checker.sv
module xpose_checker #(
    parameter int LANES    = 8,
    parameter int MAX_LEDS = 4,
    parameter int LANE_IW  = 4,
    parameter int LED_IW   = 3,
    parameter int DEPTH    = 96,
    parameter int AW       = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               pix_valid,
    input logic [LANE_IW-1:0] pix_lane,
    input logic [LED_IW-1:0]  pix_led,
    input logic               blank_req,
    input logic               gen_active,
    input logic               ready,
    input logic               err,
    input logic               ram_we,
    input logic [AW-1:0]      ram_addr
);

    logic bad_cmd;
    assign bad_cmd = (pix_lane >= LANE_IW'(LANES)) || (pix_led >= LED_IW'(MAX_LEDS));

    // R6: an accepted in-range pixel makes the block busy on the next cycle
    a_r6_busy_after_pixel: assert property (@(posedge clk) disable iff (rst)
        (ready && pix_valid && !blank_req && !bad_cmd) |=> !ready);

    // R5: an accepted blank makes the block busy on the next cycle
    a_r5_busy_after_blank: assert property (@(posedge clk) disable iff (rst)
        (ready && blank_req) |=> !ready);

    // R8: error only follows an accepted pixel command
    a_r8_err_source: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(ready && pix_valid && !blank_req && bad_cmd));

    // R8: a dropped pixel leaves the block free
    a_r8_bad_stays_free: assert property (@(posedge clk) disable iff (rst)
        (ready && pix_valid && !blank_req && bad_cmd) |=> (ready || gen_active));

    // R7: the generator's ownership excludes writes
    a_r7_no_write_in_read: assert property (@(posedge clk) disable iff (rst)
        gen_active |-> !ram_we);

    // R2: writes stay inside the plane
    a_r2_write_in_range: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr < AW'(DEPTH)));

endmodule

bind pixel_plane_xpose xpose_checker #(
    .LANES(LANES), .MAX_LEDS(MAX_LEDS), .LANE_IW(LANE_IW), .LED_IW(LED_IW),
    .DEPTH(DEPTH), .AW(AW)
) u_chk (
    .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_lane(pix_lane),
    .pix_led(pix_led), .blank_req(blank_req), .gen_active(gen_active),
    .ready(ready), .err(err), .ram_we(ram_we), .ram_addr(ram_addr)
);

// File: tb/pixel_plane_xpose_bench.sv
`timescale 1ns/1ps
module pixel_plane_xpose_bench;

    localparam int NL    = 8;
    localparam int NLED  = 4;
    localparam int DEPTH = NLED * 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_valid = 1'b0;
    logic [3:0] pix_lane = '0;
    logic [2:0] pix_led = '0;
    logic [7:0] pix_grn = '0, pix_red = '0, pix_blu = '0;
    logic       blank_req = 1'b0;
    logic       gen_active = 1'b0;
    logic [6:0] gen_addr = '0;
    logic       ready, err;
    logic [7:0] gen_data;

    int checks = 0;
    int errors = 0;
    int busy = 0;
    bit exp_err = 1'b0;
    bit cmp_en = 1'b0;
    logic [7:0] mm [DEPTH];

    always #10 clk = ~clk;

    pixel_plane_xpose u_pixel_plane_xpose (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_lane(pix_lane),
        .pix_led(pix_led), .pix_grn(pix_grn), .pix_red(pix_red), .pix_blu(pix_blu),
        .blank_req(blank_req), .gen_active(gen_active), .gen_addr(gen_addr),
        .ready(ready), .err(err), .gen_data(gen_data)
    );

    function automatic bit is_bad(logic [3:0] l, logic [2:0] d);
        return (l >= NL) || (d >= NLED);
    endfunction

    // Cycle model of handshake and error timing
    always @(posedge clk) begin
        if (rst || !cmp_en) begin
            busy    <= 0;
            exp_err <= 1'b0;
        end else begin
            exp_err <= (busy == 0) && !gen_active && pix_valid && !blank_req
                       && is_bad(pix_lane, pix_led);
            if (busy > 0) busy <= busy - 1;
            else if (!gen_active && blank_req) busy <= DEPTH;
            else if (!gen_active && pix_valid && !is_bad(pix_lane, pix_led)) busy <= 48;
        end
    end

    always @(negedge clk) begin
        if (!rst && cmp_en) begin
            checks++;
            if (ready !== ((busy == 0) && !gen_active)) begin
                errors++;
                $display("FAIL R6/R7 ready actual=%0b expected=%0b t=%0t",
                         ready, (busy == 0) && !gen_active, $time);
            end
            checks++;
            if (err !== exp_err) begin
                errors++;
                $display("FAIL R8 err actual=%0b expected=%0b t=%0t", err, exp_err, $time);
            end
        end
    end

    task automatic wait_idle();
        @(negedge clk);
        while (!ready) @(negedge clk);
    endtask

    task automatic drive_cmd(bit bl, bit pv, logic [3:0] l, logic [2:0] d,
                             logic [7:0] g, logic [7:0] r, logic [7:0] b);
        @(posedge clk); #2;
        blank_req = bl; pix_valid = pv; pix_lane = l; pix_led = d;
        pix_grn = g; pix_red = r; pix_blu = b;
        @(posedge clk); #2;
        blank_req = 1'b0; pix_valid = 1'b0;
        if (bl) begin
            for (int a = 0; a < DEPTH; a++) mm[a] = '0;
        end else if (pv && !is_bad(l, d)) begin
            logic [23:0] s;
            s = {g, r, b};
            for (int k = 0; k < 24; k++) mm[d*24 + k][l[2:0]] = s[23 - k];
        end
    endtask

    task automatic cmd(bit bl, bit pv, logic [3:0] l, logic [2:0] d,
                       logic [7:0] g, logic [7:0] r, logic [7:0] b);
        wait_idle();
        drive_cmd(bl, pv, l, d, g, r, b);
        wait_idle();
    endtask

    task automatic verify_all(string tag);
        @(posedge clk); #2;
        gen_active = 1'b1;
        for (int a = 0; a < DEPTH; a++) begin
            gen_addr = 7'(a);
            @(posedge clk); #5;
            checks++;
            if (gen_data !== mm[a]) begin
                errors++;
                $display("FAIL %s word %0d actual=%h expected=%h", tag, a, gen_data, mm[a]);
            end
            @(posedge clk); #2;
        end
        gen_active = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL R6 watchdog actual=hung expected=finished");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        checks++;
        if (ready !== 1'b1 || err !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset ready/err actual=%0b/%0b expected=1/0", ready, err);
        end
        cmp_en = 1'b1;

        // R5: blank clears everything
        cmd(1, 0, 0, 0, 0, 0, 0);
        verify_all("R5 blank");

        // R2 R3: byte placement and bit order
        cmd(0, 1, 4'd0, 3'd0, 8'h80, 8'h01, 8'hA5);
        verify_all("R2 R3 lane0 led0");

        // R4: other lanes share the same words
        cmd(0, 1, 4'd7, 3'd3, 8'h3C, 8'hFF, 8'h12);
        cmd(0, 1, 4'd3, 3'd0, 8'hFF, 8'h0F, 8'hC3);
        verify_all("R4 shared words");
        cmd(0, 1, 4'd0, 3'd0, 8'h00, 8'h00, 8'h00);
        verify_all("R4 clear one lane");

        // R8: out-of-range lane and LED
        cmd(0, 1, 4'd9, 3'd1, 8'hFF, 8'hFF, 8'hFF);
        cmd(0, 1, 4'd2, 3'd5, 8'hFF, 8'hFF, 8'hFF);
        verify_all("R8 ignored");

        // R7: commands during generator ownership are ignored
        @(posedge clk); #2;
        gen_active = 1'b1; pix_valid = 1'b1; pix_lane = 4'd1; pix_led = 3'd1;
        pix_grn = 8'hFF; pix_red = 8'hFF; pix_blu = 8'hFF;
        repeat (5) @(posedge clk);
        #2 pix_valid = 1'b0; gen_active = 1'b0;
        verify_all("R7 ignored");

        // R10: generator read interrupts an update
        cmp_en = 1'b0;
        wait_idle();
        drive_cmd(0, 1, 4'd5, 3'd0, 8'hA5, 8'h5A, 8'hE7);
        repeat (9) @(posedge clk);
        #2 gen_active = 1'b1; gen_addr = 7'd50;
        repeat (3) @(posedge clk);
        #2 gen_active = 1'b0;
        wait_idle();
        cmp_en = 1'b1;
        verify_all("R10 stall");

        // R9: single read of a known word
        @(posedge clk); #2 gen_active = 1'b1; gen_addr = 7'd72;
        @(posedge clk); #5;
        checks++;
        if (gen_data !== mm[72]) begin
            errors++;
            $display("FAIL R9 read actual=%h expected=%h", gen_data, mm[72]);
        end
        #2 gen_active = 1'b0;

        // R11: blank wins over a simultaneous pixel
        cmd(1, 1, 4'd6, 3'd2, 8'hFF, 8'hFF, 8'hFF);
        verify_all("R11 blank priority");

        repeat (3) @(posedge clk);
        summary();
    end

endmodule